// File: doc/BRIEF.md
# Switchable ISA-Variant Selector with Banked Trap Vectors

This block sits on the CSR side of one hart. It holds the active vendor/architecture identifier pair and uses it to pick which instruction-encoding engine may decode. Exactly one engine is enabled at any time. Software changes the pair by writing two identifier CSRs. The vendor CSR only stages a value. A write to the architecture CSR commits the staged vendor together with the written architecture value as one pair. If that pair is in the table of supported pairs, it becomes active on the next cycle. If it is not, the write is dropped and the old pair stays.

Each supported pair has its own machine-level and supervisor-level trap vector. The vector outputs and the vector CSRs always refer to the bank of the active pair. A switch changes the engine enable and the vector bank in the same clock edge. It then stalls the pipeline for a fixed window. A trap request that arrives during that window is held and dispatched once the window closes. It is therefore always dispatched through a bank that matches the active pair. A switch never modifies any bank contents.

Top module: `isa_variant_sel`

## Requirements
- R1: After reset, pair 0 is active (engine_en_o = 4'b0001), stall_o and trap_fire_o are 0, mtvec_o and stvec_o are 0, and the identifier CSRs read back pair 0.
- R2: Supported pair i (i = 0..3) has vendor 0x0000_0A00+i and architecture 0x8000_0000+16*i. A write to address 0x7C0 stages a vendor value. A write to 0x7C1 commits {staged vendor, written architecture}. When this matches pair i, pair i is active from the next cycle, and reads of 0x7C0/0x7C1 return its values.
- R3: engine_en_o has exactly one bit set at all times, and that bit is the index of the active pair.
- R4: A commit whose pair is not in the table changes nothing. The active pair, the reads, engine_en_o and stall_o all keep their previous values.
- R5: A legal commit raises stall_o for exactly 2 cycles, starting in the cycle where the new pair becomes active. Commit writes that arrive while stall_o is high are ignored.
- R6: trap_fire_o is never high while stall_o is high. A trap request raised during the stall is held and fires in the first cycle after stall_o falls. Outside a stall, a request fires in the same cycle.
- R7: Dispatching a trap leaves the active pair unchanged.
- R8: Writes to 0x7C2 (machine vector) and 0x7C3 (supervisor vector) update only the active pair's entry, with bits [1:0] forced to 0. mtvec_o, stvec_o and reads of these addresses show the active pair's entries.
- R9: Switching between pairs never alters any stored vector entry. Returning to a pair restores exactly the entries it had.
- R10: A write to the vendor staging address alone does not change the active pair or any read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_we_i | input | 1 | CSR write enable |
| csr_rdata_o | output | 32 | CSR read data (combinational from address) |
| engine_en_o | output | 4 | One-hot decode-engine enable |
| stall_o | output | 1 | Pipeline stall during a switch |
| trap_req_i | input | 1 | Trap request |
| trap_fire_o | output | 1 | Trap dispatched this cycle |
| mtvec_o | output | 32 | Machine trap vector of the active pair |
| stvec_o | output | 32 | Supervisor trap vector of the active pair |

## Verification
The bench walks every ordered pair of the four supported pairs, which covers every from/to switch, including a switch to the pair already active. For each switch it checks the enable pattern, the stall window and the destination bank's vectors, which separates a correct bank swap from a stale or cross-wired one. Mismatched vendor/architecture combinations and commits issued inside the stall window show whether illegal or early writes leak into state. Traps are raised both during and outside the stall, to tell held dispatch apart from immediate dispatch. Each bank is loaded with a distinct vector whose low bits are set, so a write to the wrong bank or a missing mask shows up.

// File: rtl/isa_sel_pkg.sv
package isa_sel_pkg;
  localparam int CSR_AW = 12;
  localparam logic [CSR_AW-1:0] ADDR_VID  = 12'h7C0;
  localparam logic [CSR_AW-1:0] ADDR_AID  = 12'h7C1;
  localparam logic [CSR_AW-1:0] ADDR_MVEC = 12'h7C2;
  localparam logic [CSR_AW-1:0] ADDR_SVEC = 12'h7C3;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_VID, SEL_AID, SEL_MVEC, SEL_SVEC
  } csr_sel_e;

  function automatic csr_sel_e csr_decode(input logic [CSR_AW-1:0] a);
    case (a)
      ADDR_VID:  return SEL_VID;
      ADDR_AID:  return SEL_AID;
      ADDR_MVEC: return SEL_MVEC;
      ADDR_SVEC: return SEL_SVEC;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/isa_pair_lut.sv
module isa_pair_lut #(
  parameter int NP = 4,
  parameter int IW = 2,
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VENDOR_BASE = 32'h0000_0A00,
  parameter logic [XLEN-1:0] ARCH_BASE = 32'h8000_0000,
  parameter logic [XLEN-1:0] ARCH_STEP = 32'h10
) (
  input  logic [XLEN-1:0] vendor_i,
  input  logic [XLEN-1:0] arch_i,
  input  logic [IW-1:0]   idx_i,
  output logic            hit_o,
  output logic [IW-1:0]   hit_idx_o,
  output logic [XLEN-1:0] cur_vendor_o,
  output logic [XLEN-1:0] cur_arch_o
);
  logic [XLEN-1:0] vtab [NP];
  logic [XLEN-1:0] atab [NP];

  for (genvar g = 0; g < NP; g++) begin : g_tab
    assign vtab[g] = VENDOR_BASE + XLEN'(g);
    assign atab[g] = ARCH_BASE + XLEN'(g) * ARCH_STEP;
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int k = 0; k < NP; k++) begin
      if (!hit_o && vtab[k] == vendor_i && atab[k] == arch_i) begin
        hit_o     = 1'b1;
        hit_idx_o = IW'(k);
      end
    end
  end

  assign cur_vendor_o = vtab[idx_i];
  assign cur_arch_o   = atab[idx_i];
endmodule

// File: rtl/isa_switch_ctrl.sv
module isa_switch_ctrl #(
  parameter int NP = 4,
  parameter int IW = 2,
  parameter int XLEN = 32,
  parameter int STALL_CYC = 2,
  parameter logic [XLEN-1:0] STAGE_RST = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stage_we_i,
  input  logic [XLEN-1:0] stage_data_i,
  input  logic            commit_req_i,
  input  logic            commit_hit_i,
  input  logic [IW-1:0]   commit_idx_i,
  input  logic            trap_req_i,
  output logic [XLEN-1:0] stage_o,
  output logic [IW-1:0]   active_o,
  output logic [NP-1:0]   engine_en_o,
  output logic            stall_o,
  output logic            trap_fire_o
);
  localparam int CW = $clog2(STALL_CYC + 1);

  logic [IW-1:0]   active_q;
  logic [XLEN-1:0] stage_q;
  logic [CW-1:0]   cnt_q;
  logic            pend_q;
  logic            accept;

  assign stall_o     = (cnt_q != '0);
  assign accept      = commit_req_i && commit_hit_i && !stall_o;
  assign trap_fire_o = (trap_req_i || pend_q) && !stall_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      stage_q  <= STAGE_RST;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (stage_we_i) stage_q <= stage_data_i;
      // pair and bank index move together: one register selects both
      if (accept) begin
        active_q <= commit_idx_i;
        cnt_q    <= CW'(STALL_CYC);
      end else if (stall_o) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (trap_fire_o)     pend_q <= 1'b0;
      else if (trap_req_i) pend_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_en
    assign engine_en_o[g] = (active_q == IW'(g));
  end

  assign active_o = active_q;
  assign stage_o  = stage_q;
endmodule

// File: rtl/trap_vec_bank.sv
module trap_vec_bank #(
  parameter int NP = 4,
  parameter int IW = 2,
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IW-1:0]   idx_i,
  input  logic            m_we_i,
  input  logic            s_we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] mtvec_o,
  output logic [XLEN-1:0] stvec_o
);
  logic [XLEN-1:0] m_q [NP];
  logic [XLEN-1:0] s_q [NP];
  logic [XLEN-1:0] wmask;

  assign wmask = {wdata_i[XLEN-1:2], 2'b00};

  for (genvar g = 0; g < NP; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        m_q[g] <= '0;
        s_q[g] <= '0;
      end else if (idx_i == IW'(g)) begin
        if (m_we_i) m_q[g] <= wmask;
        if (s_we_i) s_q[g] <= wmask;
      end
    end
  end

  assign mtvec_o = m_q[idx_i];
  assign stvec_o = s_q[idx_i];
endmodule

// File: rtl/isa_variant_sel.sv
module isa_variant_sel
  import isa_sel_pkg::*;
#(
  parameter int NP = 4,
  parameter int XLEN = 32,
  parameter int STALL_CYC = 2,
  parameter logic [XLEN-1:0] VENDOR_BASE = 32'h0000_0A00,
  parameter logic [XLEN-1:0] ARCH_BASE = 32'h8000_0000,
  parameter logic [XLEN-1:0] ARCH_STEP = 32'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CSR_AW-1:0] csr_addr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic              csr_we_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic [NP-1:0]     engine_en_o,
  output logic              stall_o,
  input  logic              trap_req_i,
  output logic              trap_fire_o,
  output logic [XLEN-1:0]   mtvec_o,
  output logic [XLEN-1:0]   stvec_o
);
  localparam int IW = (NP > 1) ? $clog2(NP) : 1;

  csr_sel_e        sel;
  logic [XLEN-1:0] stage, cur_vendor, cur_arch;
  logic [IW-1:0]   active, hit_idx;
  logic            hit;

  assign sel = csr_decode(csr_addr_i);

  isa_pair_lut #(
    .NP(NP), .IW(IW), .XLEN(XLEN), .VENDOR_BASE(VENDOR_BASE),
    .ARCH_BASE(ARCH_BASE), .ARCH_STEP(ARCH_STEP)
  ) u_lut (
    .vendor_i(stage), .arch_i(csr_wdata_i), .idx_i(active),
    .hit_o(hit), .hit_idx_o(hit_idx),
    .cur_vendor_o(cur_vendor), .cur_arch_o(cur_arch)
  );

  isa_switch_ctrl #(
    .NP(NP), .IW(IW), .XLEN(XLEN), .STALL_CYC(STALL_CYC), .STAGE_RST(VENDOR_BASE)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .stage_we_i(csr_we_i && sel == SEL_VID), .stage_data_i(csr_wdata_i),
    .commit_req_i(csr_we_i && sel == SEL_AID), .commit_hit_i(hit),
    .commit_idx_i(hit_idx), .trap_req_i(trap_req_i),
    .stage_o(stage), .active_o(active), .engine_en_o(engine_en_o),
    .stall_o(stall_o), .trap_fire_o(trap_fire_o)
  );

  trap_vec_bank #(.NP(NP), .IW(IW), .XLEN(XLEN)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(active),
    .m_we_i(csr_we_i && sel == SEL_MVEC), .s_we_i(csr_we_i && sel == SEL_SVEC),
    .wdata_i(csr_wdata_i), .mtvec_o(mtvec_o), .stvec_o(stvec_o)
  );

  always_comb begin
    case (sel)
      SEL_VID:  csr_rdata_o = cur_vendor;
      SEL_AID:  csr_rdata_o = cur_arch;
      SEL_MVEC: csr_rdata_o = mtvec_o;
      SEL_SVEC: csr_rdata_o = stvec_o;
      default:  csr_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/isa_sel_chk.sv
module isa_sel_chk
  import isa_sel_pkg::*;
#(
  parameter int NP = 4,
  parameter int XLEN = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CSR_AW-1:0] csr_addr_i,
  input logic              csr_we_i,
  input logic [NP-1:0]     engine_en_o,
  input logic              stall_o,
  input logic              trap_fire_o,
  input logic [XLEN-1:0]   mtvec_o,
  input logic [XLEN-1:0]   stvec_o
);
  // R3
  a_r3_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(engine_en_o) == 1);
  // R5
  a_r5_switch_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(engine_en_o) |-> $rose(stall_o));
  a_r5_stall_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |=> stall_o);
  a_r5_stall_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && $past(stall_o)) |=> !stall_o);
  // R6
  a_r6_no_fire_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !trap_fire_o);
  // R7
  a_r7_trap_keeps_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_fire_o && !(csr_we_i && csr_addr_i == ADDR_AID)) |=> $stable(engine_en_o));
  // R8
  a_r8_vec_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mtvec_o[1:0] == 2'b00 && stvec_o[1:0] == 2'b00);
endmodule

bind isa_variant_sel isa_sel_chk #(.NP(NP), .XLEN(XLEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csr_addr_i(csr_addr_i), .csr_we_i(csr_we_i),
  .engine_en_o(engine_en_o), .stall_o(stall_o), .trap_fire_o(trap_fire_o),
  .mtvec_o(mtvec_o), .stvec_o(stvec_o)
);

// File: tb/tb_isa_variant_sel.sv
`timescale 1ns/1ps
module tb_isa_variant_sel;
  import isa_sel_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_rdata;
  logic [3:0]  engine_en;
  logic        stall;
  logic        trap_req = 1'b0;
  logic        trap_fire;
  logic [31:0] mtvec, stvec;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_m [4];
  logic [31:0] exp_s [4];
  int cur = 0;

  always #4 clk = ~clk;

  isa_variant_sel dut (
    .clk_i(clk), .rst_ni(rst_ni), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
    .csr_we_i(csr_we), .csr_rdata_o(csr_rdata), .engine_en_o(engine_en),
    .stall_o(stall), .trap_req_i(trap_req), .trap_fire_o(trap_fire),
    .mtvec_o(mtvec), .stvec_o(stvec)
  );

  function automatic logic [31:0] vend(input int i); return 32'h0000_0A00 + 32'(i); endfunction
  function automatic logic [31:0] arch(input int i); return 32'h8000_0000 + 32'(i) * 32'h10; endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(posedge clk); @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic check_state(input string req);
    logic [31:0] d;
    chk({req, " engine"}, 32'(engine_en), 32'(1 << cur));
    chk({req, " mtvec"}, mtvec, exp_m[cur]);
    chk({req, " stvec"}, stvec, exp_s[cur]);
    rd(ADDR_VID, d);  chk({req, " rd vid"}, d, vend(cur));
    rd(ADDR_AID, d);  chk({req, " rd aid"}, d, arch(cur));
    rd(ADDR_MVEC, d); chk({req, " rd mvec"}, d, exp_m[cur]);
    rd(ADDR_SVEC, d); chk({req, " rd svec"}, d, exp_s[cur]);
  endtask

  // legal switch with stall window check (R2, R5)
  task automatic switch_to(input int b);
    wr(ADDR_VID, vend(b));
    wr(ADDR_AID, arch(b));
    cur = b;
    chk("R2 engine after commit", 32'(engine_en), 32'(1 << b));
    chk("R5 stall cycle 1", 32'(stall), 32'd1);
    @(negedge clk);
    chk("R5 stall cycle 2", 32'(stall), 32'd1);
    @(negedge clk);
    chk("R5 stall released", 32'(stall), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin exp_m[i] = '0; exp_s[i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_state("R1");
    chk("R1 stall", 32'(stall), 32'd0);
    chk("R1 fire", 32'(trap_fire), 32'd0);

    // R8 load every bank with distinct values, low bits set
    for (int i = 0; i < 4; i++) begin
      switch_to(i);
      wr(ADDR_MVEC, 32'h1000_0003 + 32'(i) * 32'h100);
      wr(ADDR_SVEC, 32'h2000_0007 + 32'(i) * 32'h100);
      exp_m[i] = (32'h1000_0003 + 32'(i) * 32'h100) & ~32'h3;
      exp_s[i] = (32'h2000_0007 + 32'(i) * 32'h100) & ~32'h3;
      check_state("R8");
    end

    // R2 R3 R9 all from/to combinations
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        switch_to(a);
        switch_to(b);
        check_state("R9");
      end
    end

    // R4 mismatched pair and unknown vendor
    switch_to(2);
    wr(ADDR_VID, vend(1));
    wr(ADDR_AID, arch(3));
    chk("R4 no stall", 32'(stall), 32'd0);
    check_state("R4 mixed pair");
    wr(ADDR_VID, 32'h0000_0A09);
    wr(ADDR_AID, arch(0));
    chk("R4 no stall unknown", 32'(stall), 32'd0);
    check_state("R4 unknown vendor");

    // R10 staging alone
    wr(ADDR_VID, vend(0));
    @(negedge clk);
    check_state("R10");

    // R5 commit during stall is ignored
    wr(ADDR_VID, vend(1));
    wr(ADDR_AID, arch(1));
    cur = 1;
    wr(ADDR_VID, vend(3));
    wr(ADDR_AID, arch(3));
    chk("R5 stall over", 32'(stall), 32'd0);
    check_state("R5 commit in stall");

    // R6 trap during stall is held
    wr(ADDR_VID, vend(0));
    wr(ADDR_AID, arch(0));
    cur = 0;
    trap_req = 1'b1; #1;
    chk("R6 no fire in stall", 32'(trap_fire), 32'd0);
    @(negedge clk);
    trap_req = 1'b0; #1;
    chk("R6 still held", 32'(trap_fire), 32'd0);
    @(negedge clk);
    chk("R6 stall low", 32'(stall), 32'd0);
    chk("R6 held fires", 32'(trap_fire), 32'd1);
    chk("R6 vector bank", mtvec, exp_m[0]);
    @(negedge clk);
    chk("R6 fire once", 32'(trap_fire), 32'd0);

    // R6 R7 immediate trap keeps pair
    switch_to(3);
    trap_req = 1'b1; #1;
    chk("R6 immediate fire", 32'(trap_fire), 32'd1);
    @(negedge clk);
    trap_req = 1'b0;
    @(negedge clk);
    chk("R7 fire cleared", 32'(trap_fire), 32'd0);
    check_state("R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule